// File: doc/BRIEF.md
# Packed-Row Neighbourhood Window Buffer

The block sits between a raster pixel source and a neighbourhood kernel. It writes incoming lines into a small ring of row regions that all live in one dual-port pixel memory. Whenever enough complete lines of the current frame are held, it replays the stored rows to the kernel in whatever order a small scan table asks for. Typical orders are a 3x3 window walked row by row or the same neighbourhood walked column by column. The kernel receives four pixels per system beat.

The block runs on a clock at twice the system rate. A phase bit splits every system beat into two halves. In the first half both read ports fetch two table entries and park the results in holding registers. In the second half both ports fetch the next two entries. At the end of the beat all four pixels are registered onto the output together. Pixel input and output handshakes happen only at beat ends, which are marked by `slot_end`.

When a line is completed it starts a replay job. The job steps an anchor column from 0 to the last column and, at each anchor, walks the programmed number of four-entry groups. Input is held off whenever accepting more pixels would overwrite rows that a queued job still needs.

Top module: `wb_window_buffer`

## Requirements
- R1: After reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Line k of a frame is written to row region k mod NROWS, and the region counter restarts at 0 after an end-of-frame pixel. A pixel at column c of region r sits at memory address r*2^ceil(log2(LINE_W)) + c.
- R3: Group g of anchor a in the job for line k carries table entries 4g..4g+3, with entry 4g+j in `out_pix[j*PIX_W +: PIX_W]`. Entry (dr, dc) yields the stored pixel of frame line k-(NROWS-2)+dr at column min(a+dc, LINE_W-1).
- R4: A job is started by the completion of every line k >= NROWS-2 in a frame. It emits its groups with anchors ascending from 0 to LINE_W-1 and, within an anchor, groups ascending from 0 to `scan_groups`-1. Jobs are emitted in line order.
- R5: No group is emitted for a frame until NROWS-1 of its lines have been accepted. A frame of fewer than NROWS-1 lines produces no output.
- R6: `scan_groups` (1 to TAB_DEPTH/4) sets how many four-entry groups are emitted per anchor before the walk moves to the next anchor.
- R7: While `out_valid` is 1 and `out_ready` is 0 at a beat end, the next beat shows the same `out_pix` with `out_valid` still 1.
- R8: `in_ready` is 0 while a completed-line job waits behind a running job. It is also 0 after an end-of-frame pixel until every job of that frame has been emitted.
- R9: Pixels are accepted, and output groups change, only at clock edges that end a cycle with `slot_end` = 1. With `out_ready` held at 1, the groups of one job come out on consecutive beats.
- R10: A `cfg_we` pulse writes entry `cfg_idx` of the scan table with row offset `cfg_drow` and column offset `cfg_dcol`. Later jobs use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_pix | input | PIX_W | Input pixel value |
| in_eol | input | 1 | Pixel is the last of its line |
| in_eof | input | 1 | Pixel is the last of its frame (given with in_eol) |
| in_ready | output | 1 | Buffer can accept a pixel at the next beat end |
| slot_end | output | 1 | High in the second half of each system beat |
| cfg_we | input | 1 | Scan table write strobe |
| cfg_idx | input | log2(TAB_DEPTH) | Scan table entry index |
| cfg_drow | input | log2(NROWS) | Row offset, 0 = oldest row of the job |
| cfg_dcol | input | ceil(log2(LINE_W)) | Column offset from the anchor |
| scan_groups | input | log2(TAB_DEPTH/4)+1 | Four-entry groups per anchor |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Kernel takes the group at a beat end |
| out_pix | output | 4*PIX_W | Four pixels, entry order from low bits |

## Verification
The sharpest overlap is the completion of a line at the same beat that the running job sends its last group. The sequencer has to hand over straight to the new job, neither dropping it nor leaving it pending. Short lines against long three-group jobs with an always-ready kernel produce this case many times in each frame. A second overlap is an end-of-frame pixel that arrives while a job is still queued. Here the drain hold has to keep the next frame's first line out of a row the queued job still reads, which a one-in-eight ready kernel forces. Both cases are judged by comparing every emitted group with a frame model indexed through the same scan table. The total group count of each frame is also checked.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int unsigned RD_PORTS   = 2;
  localparam int unsigned RD_PHASES  = 2;
  localparam int unsigned GROUP_PIX  = RD_PORTS * RD_PHASES;
endpackage

// File: rtl/wb_dual_phase_mem.sv
module wb_dual_phase_mem #(
  parameter int PIX_W = 8,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [PIX_W-1:0] rdata_a,
  output logic [PIX_W-1:0] rdata_b,
  output logic [PIX_W-1:0] hold_a,
  output logic [PIX_W-1:0] hold_b
);
  localparam int DEPTH = 1 << AW;

  logic [PIX_W-1:0] mem [DEPTH];

  // storage array: writes land at beat ends, reads see the old word (read-first)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // first-half results are parked until the beat end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else if (!ph) begin
      hold_a <= rdata_a;
      hold_b <= rdata_b;
    end
  end
endmodule

// File: rtl/wb_row_writer.sv
module wb_row_writer #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 16,
  parameter int NROWS  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   in_valid,
  input  logic [PIX_W-1:0]       in_pix,
  input  logic                   in_eol,
  input  logic                   in_eof,
  input  logic                   in_ready,
  output logic                   wr_en,
  output logic [$clog2(NROWS)+$clog2(LINE_W)-1:0] wr_addr,
  output logic [PIX_W-1:0]       wr_data,
  output logic                   job_req,
  output logic [$clog2(NROWS)-1:0] job_base,
  output logic                   frame_end
);
  localparam int CB = $clog2(LINE_W);
  localparam int RB = $clog2(NROWS);
  localparam logic [RB-1:0] FILL_MAX = RB'(NROWS - 2);

  logic [CB-1:0] col_q, col_d;
  logic [RB-1:0] region_q, region_d;
  logic [RB-1:0] lines_q, lines_d;
  logic          acc;

  assign acc       = tick && in_valid && in_ready;
  assign wr_en     = acc;
  assign wr_addr   = {region_q, col_q};
  assign wr_data   = in_pix;
  assign job_req   = acc && in_eol && (lines_q == FILL_MAX);
  assign job_base  = region_q + RB'(2);
  assign frame_end = acc && in_eof;

  always_comb begin
    col_d    = col_q;
    region_d = region_q;
    lines_d  = lines_q;
    if (acc) begin
      col_d = in_eol ? '0 : col_q + CB'(1);
      if (in_eol) begin
        region_d = in_eof ? '0 : region_q + RB'(1);
        lines_d  = in_eof ? '0 : ((lines_q == FILL_MAX) ? lines_q : lines_q + RB'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      region_q <= '0;
      lines_q  <= '0;
    end else if (tick) begin
      col_q    <= col_d;
      region_q <= region_d;
      lines_q  <= lines_d;
    end
  end

  // R2: a finished line that is not the frame's last moves to the next region
  p_region_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_eol && !in_eof) |=> (region_q == $past(region_q) + RB'(1)));
endmodule

// File: rtl/wb_scan_seq.sv
module wb_scan_seq #(
  parameter int LINE_W    = 16,
  parameter int NROWS     = 4,
  parameter int TAB_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick,
  input  logic                            ph,
  input  logic                            job_req,
  input  logic [$clog2(NROWS)-1:0]        job_base,
  input  logic                            frame_end,
  input  logic                            out_free,
  input  logic                            cfg_we,
  input  logic [$clog2(TAB_DEPTH)-1:0]    cfg_idx,
  input  logic [$clog2(NROWS)-1:0]        cfg_drow,
  input  logic [$clog2(LINE_W)-1:0]       cfg_dcol,
  input  logic [$clog2(TAB_DEPTH/4):0]    scan_groups,
  output logic                            in_ready,
  output logic                            load,
  output logic [$clog2(NROWS)+$clog2(LINE_W)-1:0] rd_addr_a,
  output logic [$clog2(NROWS)+$clog2(LINE_W)-1:0] rd_addr_b
);
  import wb_pkg::*;
  localparam int CB  = $clog2(LINE_W);
  localparam int RB  = $clog2(NROWS);
  localparam int AW  = RB + CB;
  localparam int TB  = $clog2(TAB_DEPTH);
  localparam int GIB = $clog2(TAB_DEPTH / GROUP_PIX);
  localparam int GB  = GIB + 1;
  localparam logic [CB:0] LAST_COL = (CB+1)'(LINE_W - 1);

  logic [RB-1:0]  tab_drow [TAB_DEPTH];
  logic [CB-1:0]  tab_dcol [TAB_DEPTH];

  logic           busy_q, busy_d;
  logic           pend_q, pend_d;
  logic           drain_q, drain_d;
  logic [RB-1:0]  base_q, base_d;
  logic [RB-1:0]  pbase_q, pbase_d;
  logic [CB-1:0]  anchor_q, anchor_d;
  logic [GIB-1:0] grp_q, grp_d;
  logic           grp_last, last, step, fin;
  logic [AW-1:0]  addr [RD_PORTS];

  // R10: scan table written at any edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAB_DEPTH; i++) begin
        tab_drow[i] <= '0;
        tab_dcol[i] <= '0;
      end
    end else if (cfg_we) begin
      tab_drow[cfg_idx] <= cfg_drow;
      tab_dcol[cfg_idx] <= cfg_dcol;
    end
  end

  // address generation: entry {group, phase, port}, column clamped at the edge
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
    logic [TB-1:0] ent;
    logic [CB:0]   csum;
    logic [CB-1:0] col;
    logic [RB-1:0] row;
    assign ent  = {grp_q, ph, 1'(p)};
    assign csum = {1'b0, anchor_q} + {1'b0, tab_dcol[ent]};
    assign col  = (csum > LAST_COL) ? LAST_COL[CB-1:0] : csum[CB-1:0];
    assign row  = base_q + tab_drow[ent];
    assign addr[p] = {row, col};
  end
  assign rd_addr_a = addr[0];
  assign rd_addr_b = addr[1];

  assign in_ready = !pend_q && !drain_q;
  assign load     = tick && busy_q && out_free;
  assign grp_last = ({1'b0, grp_q} == scan_groups - GB'(1));
  assign last     = grp_last && (anchor_q == LAST_COL[CB-1:0]);
  assign step     = load && !last;
  assign fin      = load && last;

  always_comb begin
    busy_d   = busy_q;
    pend_d   = pend_q;
    drain_d  = drain_q;
    base_d   = base_q;
    pbase_d  = pbase_q;
    anchor_d = anchor_q;
    grp_d    = grp_q;
    if (step) begin
      if (grp_last) begin
        grp_d    = '0;
        anchor_d = anchor_q + CB'(1);
      end else begin
        grp_d = grp_q + GIB'(1);
      end
    end
    if (fin) begin
      if (pend_q) begin
        pend_d   = 1'b0;
        base_d   = pbase_q;
        anchor_d = '0;
        grp_d    = '0;
      end else begin
        busy_d = 1'b0;
      end
    end
    if (job_req) begin
      if (busy_q && !fin) begin
        pend_d  = 1'b1;
        pbase_d = job_base;
      end else begin
        busy_d   = 1'b1;
        base_d   = job_base;
        anchor_d = '0;
        grp_d    = '0;
      end
    end
    if (frame_end)              drain_d = 1'b1;
    else if (!busy_q && !pend_q) drain_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      drain_q  <= 1'b0;
      base_q   <= '0;
      pbase_q  <= '0;
      anchor_q <= '0;
      grp_q    <= '0;
    end else if (tick) begin
      busy_q   <= busy_d;
      pend_q   <= pend_d;
      drain_q  <= drain_d;
      base_q   <= base_d;
      pbase_q  <= pbase_d;
      anchor_q <= anchor_d;
      grp_q    <= grp_d;
    end
  end

  // R8: a queued job always sits behind a running one
  p_pending_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy_q);
  // R6: the group index stays below the programmed length
  p_grp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, grp_q} < scan_groups));
  // R4: a new job starts at anchor 0, group 0
  p_job_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (anchor_q == '0 && grp_q == '0));
endmodule

// File: rtl/wb_window_buffer.sv
module wb_window_buffer #(
  parameter int PIX_W     = 8,
  parameter int LINE_W    = 16,
  parameter int NROWS     = 4,
  parameter int TAB_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [PIX_W-1:0]             in_pix,
  input  logic                         in_eol,
  input  logic                         in_eof,
  output logic                         in_ready,
  output logic                         slot_end,
  input  logic                         cfg_we,
  input  logic [$clog2(TAB_DEPTH)-1:0] cfg_idx,
  input  logic [$clog2(NROWS)-1:0]     cfg_drow,
  input  logic [$clog2(LINE_W)-1:0]    cfg_dcol,
  input  logic [$clog2(TAB_DEPTH/4):0] scan_groups,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [4*PIX_W-1:0]           out_pix
);
  localparam int CB = $clog2(LINE_W);
  localparam int RB = $clog2(NROWS);
  localparam int AW = RB + CB;

  logic [1:0]       rst_q;
  logic             rst_s;
  logic             ph_q;
  logic             wr_en, job_req, frame_end, load;
  logic [AW-1:0]    wr_addr, ra, rb;
  logic [PIX_W-1:0] wr_data, qa, qb, ha, hb;
  logic [RB-1:0]    job_base;
  logic             ov_q, ov_d;
  logic [4*PIX_W-1:0] op_q, op_d;
  logic             out_free;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end
  assign slot_end = ph_q;

  wb_row_writer #(.PIX_W(PIX_W), .LINE_W(LINE_W), .NROWS(NROWS)) u_wr (
    .clk(clk), .rst_n(rst_s), .tick(ph_q),
    .in_valid(in_valid), .in_pix(in_pix), .in_eol(in_eol), .in_eof(in_eof),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .job_req(job_req), .job_base(job_base), .frame_end(frame_end)
  );

  wb_scan_seq #(.LINE_W(LINE_W), .NROWS(NROWS), .TAB_DEPTH(TAB_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_s), .tick(ph_q), .ph(ph_q),
    .job_req(job_req), .job_base(job_base), .frame_end(frame_end),
    .out_free(out_free), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_drow(cfg_drow), .cfg_dcol(cfg_dcol), .scan_groups(scan_groups),
    .in_ready(in_ready), .load(load), .rd_addr_a(ra), .rd_addr_b(rb)
  );

  wb_dual_phase_mem #(.PIX_W(PIX_W), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_s), .ph(ph_q),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr_a(ra), .raddr_b(rb), .rdata_a(qa), .rdata_b(qb),
    .hold_a(ha), .hold_b(hb)
  );

  // output stage: four pixels registered together at the beat end
  assign out_free = !ov_q || out_ready;

  always_comb begin
    ov_d = ov_q;
    op_d = op_q;
    if (load) begin
      ov_d = 1'b1;
      op_d = {qb, qa, hb, ha};
    end else if (ph_q && out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ov_q <= 1'b0;
      op_q <= '0;
    end else if (ph_q) begin
      ov_q <= ov_d;
      op_q <= op_d;
    end
  end

  assign out_valid = ov_q;
  assign out_pix   = op_q;

  // R7: a refused group is held for the next beat
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (ov_q && !out_ready && ph_q) |=> (ov_q && $stable(op_q)));
  // R9: the output moves only at beat ends
  p_slot_only_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !ph_q |=> ($stable(ov_q) && $stable(op_q)));
endmodule

// File: tb/wb_window_buffer_test.sv
module wb_window_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int LINE_W = 8;
  localparam int NROWS = 4;
  localparam int TAB = 16;

  logic clk, rst_n, in_valid, in_eol, in_eof, in_ready, slot_end;
  logic [PIX_W-1:0] in_pix;
  logic cfg_we;
  logic [3:0] cfg_idx;
  logic [1:0] cfg_drow;
  logic [2:0] cfg_dcol;
  logic [2:0] scan_groups;
  logic out_valid, out_ready;
  logic [4*PIX_W-1:0] out_pix;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  wb_window_buffer #(.PIX_W(PIX_W), .LINE_W(LINE_W), .NROWS(NROWS), .TAB_DEPTH(TAB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_eol(in_eol), .in_eof(in_eof), .in_ready(in_ready), .slot_end(slot_end),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_drow(cfg_drow), .cfg_dcol(cfg_dcol),
    .scan_groups(scan_groups), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix)
  );

  // scan patterns {drow[1:0], dcol[2:0]}: 0..11 window by rows, 12..23 column-first
  localparam logic [4:0] SCAN_VEC [0:23] = '{
    5'b00_000, 5'b00_001, 5'b00_010, 5'b01_000, 5'b01_001, 5'b01_010,
    5'b10_000, 5'b10_001, 5'b10_010, 5'b01_001, 5'b00_000, 5'b10_010,
    5'b00_000, 5'b01_000, 5'b10_000, 5'b00_001, 5'b01_001, 5'b10_001,
    5'b00_010, 5'b01_010, 5'b10_010, 5'b00_011, 5'b01_011, 5'b10_011
  };

  int checks = 0, failures = 0, cyc = 0;
  int bt_drow [12];
  int bt_dcol [12];
  int cur_fid, cur_g, ready_mode;
  int mon_k, mon_a, mon_g, recv, frame_lines, low_mid, slot_cnt;
  bit mon_en = 0, frame_active = 0, stall_prev = 0;
  logic [31:0] stall_data;
  logic [7:0] lfsr = 8'h5a;

  function automatic logic [7:0] pix_val(int f, int r, int c);
    return 8'((f * 53 + r * 17 + c * 5 + 3) & 255);
  endfunction

  function automatic logic [31:0] exp_group(int f, int k, int a, int g);
    logic [31:0] v;
    v = '0;
    for (int j = 0; j < 4; j++) begin
      int e, r, c;
      e = 4 * g + j;
      r = k - (NROWS - 2) + bt_drow[e];
      c = a + bt_dcol[e];
      if (c > LINE_W - 1) c = LINE_W - 1;
      v[j*8 +: 8] = pix_val(f, r, c);
    end
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // consumer and monitor, active at the negedge before each beat end
  always @(negedge clk) begin
    if (mon_en && slot_end) begin
      logic [31:0] e;
      slot_cnt++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0];
        default: out_ready = (slot_cnt % 8 == 0);
      endcase
      if (!in_ready && frame_active) low_mid++;
      if (stall_prev)
        check(out_valid && out_pix == stall_data, "R7 held group", out_pix, stall_data);
      if (ready_mode == 0 && (mon_a != 0 || mon_g != 0))
        check(out_valid, "R9 back-to-back groups", 32'(out_valid), 32'd1);
      if (out_valid && out_ready) begin
        check(frame_lines >= NROWS - 1, "R5 early group", 32'(frame_lines), 32'(NROWS - 1));
        e = exp_group(cur_fid, mon_k, mon_a, mon_g);
        check(out_pix == e, "R2 R3 R10 group value", out_pix, e);
        recv++;
        mon_g++;
        if (mon_g == cur_g) begin
          mon_g = 0;
          mon_a++;
          if (mon_a == LINE_W) begin
            mon_a = 0;
            mon_k++;
          end
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_pix;
    end
  end

  task automatic send_pix(logic [7:0] v, bit eol, bit eof);
    do @(negedge clk); while (!(slot_end && in_ready));
    in_valid = 1'b1; in_pix = v; in_eol = eol; in_eof = eof;
    @(negedge clk);
    in_valid = 1'b0; in_eol = 1'b0; in_eof = 1'b0;
    if (eol) frame_lines++;
  endtask

  task automatic load_table(int off);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 4'(i);
      cfg_drow = SCAN_VEC[off + i][4:3];
      cfg_dcol = SCAN_VEC[off + i][2:0];
      bt_drow[i] = int'(SCAN_VEC[off + i][4:3]);
      bt_dcol[i] = int'(SCAN_VEC[off + i][2:0]);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(int fid, int h, int g, int mode, int off, string tag);
    int expn, w;
    load_table(off);
    scan_groups = 3'(g);
    cur_fid = fid; cur_g = g; ready_mode = mode;
    mon_k = NROWS - 2; mon_a = 0; mon_g = 0; recv = 0;
    frame_lines = 0; low_mid = 0;
    expn = (h >= NROWS - 1) ? (h - (NROWS - 2)) * LINE_W * g : 0;
    frame_active = 1;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < LINE_W; c++)
        send_pix(pix_val(fid, r, c), c == LINE_W - 1, (r == h - 1) && (c == LINE_W - 1));
    frame_active = 0;
    w = 0;
    while (!(recv == expn && in_ready && w >= 60) && w < 60000) begin
      @(negedge clk);
      w++;
    end
    check(recv == expn, {tag, " group count"}, 32'(recv), 32'(expn));
    check(in_ready == 1'b1, "R8 input reopens after frame", 32'(in_ready), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; in_eol = 1'b0; in_eof = 1'b0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_drow = '0; cfg_dcol = '0; scan_groups = 3'd1;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
    mon_en = 1;
    // R3 R4 R9: row-major window, always-ready kernel
    run_frame(0, 6, 3, 0, 0, "R4 frame0");
    // R7 R10: table reloaded column-first, random backpressure
    run_frame(1, 6, 3, 1, 12, "R4 R10 frame1");
    // R6 R8: one group per anchor, slow kernel forces input stalls
    run_frame(2, 5, 1, 2, 0, "R4 R6 frame2");
    check(low_mid > 0, "R8 input held during frame", 32'(low_mid), 32'd1);
    // R5: too few lines, nothing emitted
    run_frame(3, 2, 3, 0, 0, "R5 short frame");
    // R2: region counter restarted, two groups per anchor
    run_frame(4, 4, 2, 0, 12, "R2 R6 frame4");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule